// File: doc/BRIEF.md
# GPIO Port Register Controller

This block is the register side of a 32-pin general-purpose I/O port. A host reaches it through a simple 32-bit register bus. Each access is one request cycle, and the response follows exactly one cycle later. The block stores the output data word, the per-pin direction word, a sampled copy of the pads, a 64-bit trigger configuration split over two words, an interrupt mask and a sticky interrupt status word. A both-edge select word is included when a build parameter enables it.

Output-configured pins drive the stored data bits. Input pins are captured every cycle into the pad copy. A read of the data word returns the driven value on output pins and the sampled value on input pins. The trigger logic for each pin lives outside this block. It reads the configuration words from the block, raises status bits through a set vector, and receives a one-cycle rescan pulse whenever a write changes what it must evaluate. The interrupt outputs combine the status word with the mask. They form either one line or two lines, one for the low half of the pins and one for the high half.

Top module: `gpio_port_regs`

## Requirements
- R1: Reset is synchronous and active low. It clears every stored word: data, direction, pad copy, both trigger words, mask, status and both-edge select. After reset every decoded register reads 0, `pad_oe` is 0 and `irq` is 0.
- R2: Byte offsets 0x00 (data), 0x04 (direction), 0x0C (trigger low), 0x10 (trigger high) and 0x14 (mask) are read/write over the full 32 bits. For a request in cycle k, the response (`rsp_valid`, `rsp_rdata`, `rsp_err`) is valid in cycle k+1. Writes respond with data 0.
- R3: A read of offset 0x00 returns `(data & dir) | (pad & ~dir)`. `pad_out` equals the data word and `pad_oe` equals the direction word, starting in the cycle after the write.
- R4: The pad copy takes `pad_in` on every clock edge. A read of offset 0x08 returns `pad & ~dir`. A write to 0x08 is accepted without error and changes nothing.
- R5: `trig_cfg` is `{trigger high, trigger low}`. Pin n is configured by bits [2n+1:2n].
- R6: Status bit n (offset 0x18) is set by `trig_set[n]` and stays set until cleared. A write to 0x18 clears each bit written with 1 and leaves bits written with 0 unchanged. A set and a clear of the same bit in the same cycle leave it set.
- R7: With `SPLIT_IRQ`=1, `irq[0]` is the OR of (status & mask) bits 15:0 and `irq[1]` is the OR of bits 31:16. With `SPLIT_IRQ`=0, `irq[0]` is the OR of all 32 bits and `irq[1]` is 0.
- R8: With `HAS_BOTH_EDGE`=1, offset 0x1C is a read/write register driven onto `both_edge`. With `HAS_BOTH_EDGE`=0, an access to 0x1C reads 0, writes nothing, reports `rsp_err`=1, and `both_edge` stays 0.
- R9: An access whose offset is not one of the eight listed, is not 4-byte aligned, or has `req_be` other than 4'hF is rejected. It reads 0, changes no register and reports `rsp_err`=1 for the one response cycle only.
- R10: `rescan` pulses high for one cycle, in the response cycle, after an accepted write to direction, trigger low, trigger high, status or both-edge select. Accepted writes to data, mask or the pad copy do not pulse it, and neither do reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset |
| req_be | input | 4 | Byte enables; only 4'hF is legal |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_rdata | output | 32 | Read data (0 for writes and rejected accesses) |
| rsp_err | output | 1 | Access rejected |
| pad_in | input | 32 | Pad input levels |
| pad_out | output | 32 | Pad output drive values |
| pad_oe | output | 32 | Pad output enables (1 = output) |
| trig_set | input | 32 | Status set requests from the trigger evaluator |
| trig_cfg | output | 64 | Per-pin 2-bit trigger configuration |
| both_edge | output | 32 | Per-pin both-edge select |
| dir_cfg | output | 32 | Direction word, for the trigger evaluator |
| rescan | output | 1 | Request to re-evaluate all pin trigger conditions |
| irq | output | 2 | Interrupt lines |

## Verification
The bench builds two instances. The first has `HAS_BOTH_EDGE`=1 and `SPLIT_IRQ`=1. It covers the both-edge register and the separate low-half and high-half interrupt lines. The second has `HAS_BOTH_EDGE`=0 and `SPLIT_IRQ`=0, so the error path for the missing register and the single merged interrupt line can be observed. Between them, both generate branches of the optional register and of the interrupt combiner are exercised.

// File: rtl/gpio_port_pkg.sv
// Package: shared constants and types for the GPIO port register block.
// Assumes a 32-bit register bus and a 32-pin port.
package gpio_port_pkg;

    localparam int WORD_W = 32;
    localparam int N_REGS = 8;
    localparam int IDX_W  = 3;

    // Register slot index; the byte offset is index * 4.
    typedef enum logic [IDX_W-1:0] {
        RIDX_DATA    = 3'd0,
        RIDX_DIR     = 3'd1,
        RIDX_PAD     = 3'd2,
        RIDX_TRIG_LO = 3'd3,
        RIDX_TRIG_HI = 3'd4,
        RIDX_MASK    = 3'd5,
        RIDX_STAT    = 3'd6,
        RIDX_BOTH    = 3'd7
    } reg_idx_e;

    // Slots whose accepted write requests a trigger re-evaluation.
    localparam logic [N_REGS-1:0] RESCAN_SLOTS =
        (N_REGS'(1) << RIDX_DIR)     |
        (N_REGS'(1) << RIDX_TRIG_LO) |
        (N_REGS'(1) << RIDX_TRIG_HI) |
        (N_REGS'(1) << RIDX_STAT)    |
        (N_REGS'(1) << RIDX_BOTH);

    // Snapshot of all stored words, passed from storage to readers.
    typedef struct packed {
        logic [WORD_W-1:0]   data;
        logic [WORD_W-1:0]   dir;
        logic [WORD_W-1:0]   pad;
        logic [2*WORD_W-1:0] trig;
        logic [WORD_W-1:0]   mask;
        logic [WORD_W-1:0]   stat;
        logic [WORD_W-1:0]   both;
    } reg_view_t;

endpackage

// File: rtl/gpio_port_decode.sv
// Module: address and access decoder.
// Turns one bus request into a one-hot slot select, or flags it as rejected.
// Assumes byte addressing with word-aligned registers in the lowest 32 bytes.
module gpio_port_decode
    import gpio_port_pkg::*;
#(
    parameter int ADDR_W        = 8,
    parameter bit HAS_BOTH_EDGE = 1'b1
) (
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [3:0]          req_be,
    output logic [N_REGS-1:0]   sel_o,
    output logic [N_REGS-1:0]   wr_sel_o,
    output logic                rd_hit_o,
    output logic                err_o
);

    localparam int SLOT_LSB = 2;
    localparam int SLOT_MSB = SLOT_LSB + IDX_W - 1;

    logic              upper_zero;
    logic              aligned;
    logic              full_word;
    logic              slot_present;
    logic              accept;
    logic [IDX_W-1:0]  slot;

    // Offsets above the register window are never decoded.
    generate
        if (ADDR_W > SLOT_MSB + 1) begin : g_upper
            assign upper_zero = ~|req_addr[ADDR_W-1:SLOT_MSB+1];
        end else begin : g_no_upper
            assign upper_zero = 1'b1;
        end
    endgenerate

    assign slot = req_addr[SLOT_MSB:SLOT_LSB];

    // Check the alignment, width and presence conditions of the access.
    always_comb begin
        aligned      = (req_addr[SLOT_LSB-1:0] == '0);
        full_word    = (req_be == 4'hF);
        slot_present = HAS_BOTH_EDGE || (slot != RIDX_BOTH);
        accept       = req_valid && upper_zero && aligned && full_word && slot_present;
    end

    // Produce selects and the reject flag.
    always_comb begin
        sel_o    = accept ? (N_REGS'(1) << slot) : '0;
        wr_sel_o = req_write ? sel_o : '0;
        rd_hit_o = accept && !req_write;
        err_o    = req_valid && !accept;
    end

endmodule

// File: rtl/gpio_port_store.sv
// Module: register storage.
// Holds the data, direction, pad copy, trigger, mask, status and optional
// both-edge words. Assumes at most one slot write per cycle (one-hot wr_sel).
module gpio_port_store
    import gpio_port_pkg::*;
#(
    parameter bit HAS_BOTH_EDGE = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_REGS-1:0]   wr_sel,
    input  logic [WORD_W-1:0]   wdata,
    input  logic [WORD_W-1:0]   pad_in,
    input  logic [WORD_W-1:0]   trig_set,
    output reg_view_t           view_o
);

    logic [WORD_W-1:0]   data_q;
    logic [WORD_W-1:0]   dir_q;
    logic [WORD_W-1:0]   pad_q;
    logic [WORD_W-1:0]   trig_lo_q;
    logic [WORD_W-1:0]   trig_hi_q;
    logic [WORD_W-1:0]   mask_q;
    logic [WORD_W-1:0]   stat_q;
    logic [WORD_W-1:0]   both_w;
    logic [WORD_W-1:0]   stat_clr;

    // Plain read/write words written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q    <= '0;
            dir_q     <= '0;
            trig_lo_q <= '0;
            trig_hi_q <= '0;
            mask_q    <= '0;
        end else begin
            if (wr_sel[RIDX_DATA])    data_q    <= wdata;
            if (wr_sel[RIDX_DIR])     dir_q     <= wdata;
            if (wr_sel[RIDX_TRIG_LO]) trig_lo_q <= wdata;
            if (wr_sel[RIDX_TRIG_HI]) trig_hi_q <= wdata;
            if (wr_sel[RIDX_MASK])    mask_q    <= wdata;
        end
    end

    // Pad copy samples the pins every cycle; bus writes do not reach it.
    always_ff @(posedge clk) begin
        if (!rst_n) pad_q <= '0;
        else        pad_q <= pad_in;
    end

    // Status clear mask: ones written to the status slot.
    always_comb begin
        stat_clr = wr_sel[RIDX_STAT] ? wdata : '0;
    end

    // Sticky status: set requests win over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~stat_clr) | trig_set;
    end

    // Optional both-edge select word.
    generate
        if (HAS_BOTH_EDGE) begin : g_both
            logic [WORD_W-1:0] both_q;

            // Both-edge select storage.
            always_ff @(posedge clk) begin
                if (!rst_n)                 both_q <= '0;
                else if (wr_sel[RIDX_BOTH]) both_q <= wdata;
            end
            assign both_w = both_q;
        end else begin : g_no_both
            assign both_w = '0;
        end
    endgenerate

    // Gather the stored words into one view.
    always_comb begin
        view_o.data = data_q;
        view_o.dir  = dir_q;
        view_o.pad  = pad_q;
        view_o.trig = {trig_hi_q, trig_lo_q};
        view_o.mask = mask_q;
        view_o.stat = stat_q;
        view_o.both = both_w;
    end

    AST_PAD_FOLLOWS_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (pad_q == $past(pad_in)))
        else $error("pad copy lost a sample"); // R4

    AST_STAT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sel[RIDX_STAT] |=> ((stat_q & $past(wdata & ~trig_set)) == '0))
        else $error("status bit survived a clear"); // R6

    AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_sel[RIDX_STAT] |=> ((stat_q & $past(stat_q)) == $past(stat_q)))
        else $error("status bit dropped without a clear"); // R6

    AST_DIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_sel[RIDX_DIR] |=> $stable(dir_q))
        else $error("direction changed without a write"); // R2

endmodule

// File: rtl/gpio_port_rdmux.sv
// Module: read data selection.
// Returns the word for the selected slot, merging pad and data per pin for
// the data slot and masking output pins in the pad slot. Zero when no slot.
module gpio_port_rdmux
    import gpio_port_pkg::*;
(
    input  reg_view_t           view,
    input  logic [N_REGS-1:0]   sel,
    output logic [WORD_W-1:0]   rdata_o
);

    logic [WORD_W-1:0] slot_word [N_REGS];

    // Per-slot read values.
    always_comb begin
        slot_word[RIDX_DATA]    = (view.data & view.dir) | (view.pad & ~view.dir);
        slot_word[RIDX_DIR]     = view.dir;
        slot_word[RIDX_PAD]     = view.pad & ~view.dir;
        slot_word[RIDX_TRIG_LO] = view.trig[WORD_W-1:0];
        slot_word[RIDX_TRIG_HI] = view.trig[2*WORD_W-1:WORD_W];
        slot_word[RIDX_MASK]    = view.mask;
        slot_word[RIDX_STAT]    = view.stat;
        slot_word[RIDX_BOTH]    = view.both;
    end

    // AND-OR selection over the one-hot select.
    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < N_REGS; i++) begin
            rdata_o |= sel[i] ? slot_word[i] : '0;
        end
    end

endmodule

// File: rtl/gpio_port_irq.sv
// Module: interrupt line combiner.
// Reduces masked status to one line, or to two lines split at the middle pin.
module gpio_port_irq
    import gpio_port_pkg::*;
#(
    parameter bit SPLIT_IRQ = 1'b0
) (
    input  logic [WORD_W-1:0]   stat,
    input  logic [WORD_W-1:0]   mask,
    output logic [1:0]          irq_o
);

    localparam int HALF = WORD_W / 2;

    logic [WORD_W-1:0] pend;

    // Pending = status bits that are unmasked.
    always_comb pend = stat & mask;

    generate
        if (SPLIT_IRQ) begin : g_split
            // Low-half and high-half lines.
            always_comb begin
                irq_o[0] = |pend[HALF-1:0];
                irq_o[1] = |pend[WORD_W-1:HALF];
            end
        end else begin : g_single
            // One merged line; the second is tied low.
            always_comb begin
                irq_o[0] = |pend;
                irq_o[1] = 1'b0;
            end
        end
    endgenerate

endmodule

// File: rtl/gpio_port_regs.sv
// Module: GPIO port register controller (top).
// One request per cycle on a 32-bit register bus; the response is registered
// and appears in the next cycle. Trigger evaluation is external: it reads
// trig_cfg, both_edge and dir_cfg, drives trig_set, and rescans on rescan.
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int ADDR_W        = 8,
    parameter bit HAS_BOTH_EDGE = 1'b1,
    parameter bit SPLIT_IRQ     = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [3:0]          req_be,
    input  logic [31:0]         req_wdata,
    output logic                rsp_valid,
    output logic [31:0]         rsp_rdata,
    output logic                rsp_err,
    input  logic [31:0]         pad_in,
    output logic [31:0]         pad_out,
    output logic [31:0]         pad_oe,
    input  logic [31:0]         trig_set,
    output logic [63:0]         trig_cfg,
    output logic [31:0]         both_edge,
    output logic [31:0]         dir_cfg,
    output logic                rescan,
    output logic [1:0]          irq
);

    logic [N_REGS-1:0] sel;
    logic [N_REGS-1:0] wr_sel;
    logic              rd_hit;
    logic              acc_err;
    reg_view_t         view;
    logic [WORD_W-1:0] rd_word;

    logic              rsp_valid_q;
    logic [WORD_W-1:0] rsp_rdata_q;
    logic              rsp_err_q;
    logic              rescan_q;

    gpio_port_decode #(
        .ADDR_W        (ADDR_W),
        .HAS_BOTH_EDGE (HAS_BOTH_EDGE)
    ) i_decode (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_be    (req_be),
        .sel_o     (sel),
        .wr_sel_o  (wr_sel),
        .rd_hit_o  (rd_hit),
        .err_o     (acc_err)
    );

    gpio_port_store #(
        .HAS_BOTH_EDGE (HAS_BOTH_EDGE)
    ) i_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_sel   (wr_sel),
        .wdata    (req_wdata),
        .pad_in   (pad_in),
        .trig_set (trig_set),
        .view_o   (view)
    );

    gpio_port_rdmux i_rdmux (
        .view    (view),
        .sel     (sel),
        .rdata_o (rd_word)
    );

    gpio_port_irq #(
        .SPLIT_IRQ (SPLIT_IRQ)
    ) i_irq (
        .stat  (view.stat),
        .mask  (view.mask),
        .irq_o (irq)
    );

    // Register the bus response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_rdata_q <= '0;
            rsp_err_q   <= 1'b0;
        end else begin
            rsp_valid_q <= req_valid;
            rsp_rdata_q <= rd_hit ? rd_word : '0;
            rsp_err_q   <= acc_err;
        end
    end

    // Pulse the rescan request after writes that affect trigger evaluation.
    always_ff @(posedge clk) begin
        if (!rst_n) rescan_q <= 1'b0;
        else        rescan_q <= |(wr_sel & RESCAN_SLOTS);
    end

    // Drive the pin and configuration outputs straight from storage.
    always_comb begin
        rsp_valid = rsp_valid_q;
        rsp_rdata = rsp_rdata_q;
        rsp_err   = rsp_err_q;
        rescan    = rescan_q;
        pad_out   = view.data;
        pad_oe    = view.dir;
        dir_cfg   = view.dir;
        trig_cfg  = view.trig;
        both_edge = view.both;
    end

    AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid)
        else $error("request without a response"); // R2

    AST_RSP_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid)
        else $error("response without a request"); // R2

    AST_ERR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_valid && rsp_rdata == '0))
        else $error("rejected access returned data"); // R9

    AST_RESCAN_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        rescan |-> $past(req_valid && req_write))
        else $error("rescan without a write"); // R10

    AST_NO_IRQ_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (view.mask == '0) |-> (irq == 2'b00))
        else $error("interrupt with everything masked"); // R7

    AST_ABSENT_BOTH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !HAS_BOTH_EDGE |-> (both_edge == '0))
        else $error("missing register drove both_edge"); // R8

endmodule

// File: tb/test_gpio_port_regs.sv
// Bench: scoreboard style. The bus task queues the expected response; the
// monitor pops and compares each response as it appears.
module test_gpio_port_regs;

    localparam int CLK_P = 10;

    localparam logic [7:0] A_DATA = 8'h00;
    localparam logic [7:0] A_DIR  = 8'h04;
    localparam logic [7:0] A_PAD  = 8'h08;
    localparam logic [7:0] A_TLO  = 8'h0C;
    localparam logic [7:0] A_THI  = 8'h10;
    localparam logic [7:0] A_MASK = 8'h14;
    localparam logic [7:0] A_STAT = 8'h18;
    localparam logic [7:0] A_BOTH = 8'h1C;

    typedef struct {
        logic [31:0] data;
        logic        err;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [3:0]  req_be = 4'hF;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_err;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;
    logic [31:0] trig_set = '0;
    logic [63:0] trig_cfg;
    logic [31:0] both_edge;
    logic [31:0] dir_cfg;
    logic        rescan;
    logic [1:0]  irq;

    logic        l_req_valid = 1'b0;
    logic        l_req_write = 1'b0;
    logic [7:0]  l_req_addr = '0;
    logic [31:0] l_req_wdata = '0;
    logic        l_rsp_valid;
    logic [31:0] l_rsp_rdata;
    logic        l_rsp_err;
    logic [31:0] l_pad_out;
    logic [31:0] l_pad_oe;
    logic [31:0] l_trig_set = '0;
    logic [63:0] l_trig_cfg;
    logic [31:0] l_both_edge;
    logic [31:0] l_dir_cfg;
    logic        l_rescan;
    logic [1:0]  l_irq;

    int   n_chk = 0;
    int   n_err = 0;
    bit   done  = 1'b0;
    exp_t sb_q[$];

    always #(CLK_P/2) clk = ~clk;

    gpio_port_regs #(.ADDR_W(8), .HAS_BOTH_EDGE(1'b1), .SPLIT_IRQ(1'b1)) i_gpio_port_regs (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_be(req_be), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .trig_set(trig_set), .trig_cfg(trig_cfg), .both_edge(both_edge),
        .dir_cfg(dir_cfg), .rescan(rescan), .irq(irq)
    );

    gpio_port_regs #(.ADDR_W(8), .HAS_BOTH_EDGE(1'b0), .SPLIT_IRQ(1'b0)) i_gpio_port_regs_lite (
        .clk(clk), .rst_n(rst_n),
        .req_valid(l_req_valid), .req_write(l_req_write), .req_addr(l_req_addr),
        .req_be(4'hF), .req_wdata(l_req_wdata),
        .rsp_valid(l_rsp_valid), .rsp_rdata(l_rsp_rdata), .rsp_err(l_rsp_err),
        .pad_in(32'h0), .pad_out(l_pad_out), .pad_oe(l_pad_oe),
        .trig_set(l_trig_set), .trig_cfg(l_trig_cfg), .both_edge(l_both_edge),
        .dir_cfg(l_dir_cfg), .rescan(l_rescan), .irq(l_irq)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: one request cycle, expected response pushed to the scoreboard.
    task automatic bus(input logic wr, input logic [7:0] a, input logic [31:0] wd,
                       input logic [3:0] be, input logic [31:0] trig,
                       input logic [31:0] exp_d, input logic exp_e, input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = wd;
        req_be    = be;
        trig_set  = trig;
        e.data = exp_d;
        e.err  = exp_e;
        e.tag  = tag;
        sb_q.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
        req_be    = 4'hF;
        trig_set  = '0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
        bus(1'b1, a, d, 4'hF, '0, '0, 1'b0, tag);
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        bus(1'b0, a, '0, 4'hF, '0, exp, 1'b0, tag);
    endtask

    // Direct access to the second instance; result captured in the response cycle.
    task automatic lite_acc(input logic w, input logic [7:0] a, input logic [31:0] d,
                            output logic [31:0] rdata, output logic err);
        @(negedge clk);
        l_req_valid = 1'b1;
        l_req_write = w;
        l_req_addr  = a;
        l_req_wdata = d;
        @(negedge clk);
        l_req_valid = 1'b0;
        l_req_write = 1'b0;
        chk("R2 lite response valid", 64'(l_rsp_valid), 64'd1);
        rdata = l_rsp_rdata;
        err   = l_rsp_err;
    endtask

    // Monitor: compare each response against the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb_q.size() == 0) begin
                n_chk++;
                n_err++;
                $display("FAIL R2 unexpected response actual=%h expected=none", rsp_rdata);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk({e.tag, " rdata"}, 64'(rsp_rdata), 64'(e.data));
                chk({e.tag, " err"}, 64'(rsp_err), 64'(e.err));
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin : watchdog
        #(CLK_P * 50000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin : stim
        logic [31:0] lr;
        logic        le;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state.
        chk("R1 pad_oe after reset", 64'(pad_oe), 64'd0);
        chk("R1 irq after reset", 64'(irq), 64'd0);
        chk("R1 trig_cfg after reset", trig_cfg, 64'd0);
        rd(A_DATA, 32'h0, "R1 data");
        rd(A_DIR,  32'h0, "R1 dir");
        rd(A_PAD,  32'h0, "R1 pad");
        rd(A_TLO,  32'h0, "R1 trig lo");
        rd(A_THI,  32'h0, "R1 trig hi");
        rd(A_MASK, 32'h0, "R1 mask");
        rd(A_STAT, 32'h0, "R1 status");
        rd(A_BOTH, 32'h0, "R1 both");

        // R2, R10: plain registers and rescan behaviour.
        wr(A_DATA, 32'hA5A5_0F0F, "R2 write data");
        chk("R10 no rescan after data write", 64'(rescan), 64'd0);
        wr(A_DIR, 32'hFFFF_0000, "R2 write dir");
        chk("R10 rescan after dir write", 64'(rescan), 64'd1);
        @(negedge clk);
        chk("R10 rescan lasts one cycle", 64'(rescan), 64'd0);
        wr(A_TLO, 32'h1234_5678, "R2 write trig lo");
        chk("R10 rescan after trig lo write", 64'(rescan), 64'd1);
        wr(A_THI, 32'h9ABC_DEF0, "R2 write trig hi");
        wr(A_MASK, 32'h0, "R2 write mask");
        chk("R10 no rescan after mask write", 64'(rescan), 64'd0);
        rd(A_DIR,  32'hFFFF_0000, "R2 dir readback");
        chk("R10 no rescan after read", 64'(rescan), 64'd0);
        rd(A_TLO,  32'h1234_5678, "R2 trig lo readback");
        rd(A_THI,  32'h9ABC_DEF0, "R2 trig hi readback");
        chk("R5 trig_cfg", trig_cfg, 64'h9ABC_DEF0_1234_5678);
        chk("R5 pin 0 field", 64'(trig_cfg[1:0]), 64'h0);
        chk("R5 pin 31 field", 64'(trig_cfg[63:62]), 64'h2);

        // R3, R4: data merge and pad copy.
        @(negedge clk);
        pad_in = 32'h3C3C_C3C3;
        @(negedge clk);
        chk("R3 pad_out", 64'(pad_out), 64'hA5A5_0F0F);
        chk("R3 pad_oe", 64'(pad_oe), 64'hFFFF_0000);
        rd(A_DATA, 32'hA5A5_C3C3, "R3 merged data read");
        rd(A_PAD,  32'h0000_C3C3, "R4 pad read masks outputs");
        wr(A_PAD, 32'hFFFF_FFFF, "R4 pad write accepted");
        chk("R10 no rescan after pad write", 64'(rescan), 64'd0);
        rd(A_PAD,  32'h0000_C3C3, "R4 pad write ignored");
        wr(A_DIR, 32'h0000_FFFF, "R3 flip direction");
        rd(A_DATA, 32'h3C3C_0F0F, "R3 merged after flip");
        wr(A_DIR, 32'hFFFF_0000, "R3 restore direction");

        // R6, R7: status and interrupt lines.
        bus(1'b0, A_STAT, '0, 4'hF, 32'h0001_0002, 32'h0, 1'b0, "R6 read while setting");
        rd(A_STAT, 32'h0001_0002, "R6 status set");
        chk("R7 masked off", 64'(irq), 64'd0);
        wr(A_MASK, 32'h0000_0002, "R7 mask low");
        chk("R7 low line", 64'(irq), 64'b01);
        wr(A_MASK, 32'h0001_0000, "R7 mask high");
        chk("R7 high line", 64'(irq), 64'b10);
        wr(A_MASK, 32'hFFFF_FFFF, "R7 mask all");
        chk("R7 both lines", 64'(irq), 64'b11);
        wr(A_STAT, 32'h0000_0002, "R6 clear bit 1");
        chk("R10 rescan after status write", 64'(rescan), 64'd1);
        rd(A_STAT, 32'h0001_0000, "R6 after clear");
        chk("R7 low line drops", 64'(irq), 64'b10);
        wr(A_STAT, 32'h0000_0000, "R6 zero write");
        rd(A_STAT, 32'h0001_0000, "R6 zero write keeps bits");
        bus(1'b1, A_STAT, 32'h0001_0000, 4'hF, 32'h0001_0000, 32'h0, 1'b0, "R6 set vs clear");
        rd(A_STAT, 32'h0001_0000, "R6 set wins");
        wr(A_STAT, 32'hFFFF_FFFF, "R6 clear all");
        rd(A_STAT, 32'h0, "R6 all cleared");
        chk("R7 lines idle", 64'(irq), 64'b00);

        // R8: both-edge register present.
        wr(A_BOTH, 32'h8000_0001, "R8 write both");
        chk("R10 rescan after both write", 64'(rescan), 64'd1);
        chk("R8 both_edge output", 64'(both_edge), 64'h8000_0001);
        rd(A_BOTH, 32'h8000_0001, "R8 both readback");

        // R9: rejected accesses.
        bus(1'b0, 8'h20, '0, 4'hF, '0, 32'h0, 1'b1, "R9 read past window");
        @(negedge clk);
        chk("R9 err lasts one cycle", 64'(rsp_err), 64'd0);
        bus(1'b1, 8'h20, 32'hFFFF_FFFF, 4'hF, '0, 32'h0, 1'b1, "R9 write past window");
        bus(1'b0, 8'h03, '0, 4'hF, '0, 32'h0, 1'b1, "R9 misaligned read");
        bus(1'b1, 8'h02, 32'h0, 4'hF, '0, 32'h0, 1'b1, "R9 misaligned write");
        bus(1'b1, A_DATA, 32'h0000_0000, 4'h3, '0, 32'h0, 1'b1, "R9 partial write");
        chk("R10 no rescan after rejected write", 64'(rescan), 64'd0);
        bus(1'b0, A_DIR, '0, 4'h1, '0, 32'h0, 1'b1, "R9 partial read");
        rd(A_DATA, 32'hA5A5_C3C3, "R9 data unchanged");
        rd(A_BOTH, 32'h8000_0001, "R9 both unchanged");

        // R7, R8: second instance without the optional register, one line.
        lite_acc(1'b1, A_BOTH, 32'hFFFF_FFFF, lr, le);
        chk("R8 absent write err", 64'(le), 64'd1);
        chk("R10 absent write no rescan", 64'(l_rescan), 64'd0);
        lite_acc(1'b0, A_BOTH, '0, lr, le);
        chk("R8 absent read data", 64'(lr), 64'd0);
        chk("R8 absent read err", 64'(le), 64'd1);
        chk("R8 absent both_edge", 64'(l_both_edge), 64'd0);
        lite_acc(1'b1, A_MASK, 32'h0001_0000, lr, le);
        chk("R2 lite mask write ok", 64'(le), 64'd0);
        @(negedge clk);
        l_trig_set = 32'h0001_0000;
        @(negedge clk);
        l_trig_set = '0;
        chk("R7 single line from high pin", 64'(l_irq), 64'b01);
        lite_acc(1'b1, A_STAT, 32'h0001_0000, lr, le);
        chk("R7 single line clears", 64'(l_irq), 64'b00);

        repeat (3) @(negedge clk);
        n_chk++;
        if (sb_q.size() != 0) begin
            n_err++;
            $display("FAIL R2 missing responses actual=%0d expected=0", sb_q.size());
        end
        finish_run();
    end

endmodule